// File: doc/BRIEF.md
# Marker-Embedding Byte-to-Word Encoder

This block turns each incoming byte into a 10-bit code word that always carries the 4-bit marker pattern `0101` somewhere inside it. The upper two bits of the byte select one of four groups. Within each group, a secondary field picks where the marker sits and how the remaining data bits are spread around it. The mapping needs no lookup table. One input value is reserved and maps to a fixed word, so that the word range `150h`–`15Fh` is never reached by any other byte.

The result is registered. When no byte is offered but the link wants filler, the block emits idle words that alternate between `155h` and `2AAh` and raises a flag that marks them as idle. When neither a byte nor an idle request is present, the output holds its last word.

Top module: `mkenc_top`

## Requirements
- R1: For a byte with bits 7:6 = 00 and bits 5:4 ≠ 01, the word (bit 9 first) is `0101` followed by byte bits 5:0.
- R2: For a byte with bits 7:6 = 00 and bits 5:4 = 01, the word (bit 9 first) is 1, b2, b3, b1, `00101`, b0.
- R3: For a byte with bits 7:6 = 01, the word is b5, `0101`, b4..b0. The exception is byte `6Ah`, which always gives `154h`.
- R4: For a byte with bits 7:6 = 10, bits 5:4 = 01 give b3 b2 `00` b1 b0 `0101`. Any other value gives b5 b4 `0101` b3..b0.
- R5: For a byte with bits 7:6 = 11, bits 4:3 = 01 give b5 b2 `11` b1 b0 `0101`. Any other value gives b5 b4 b3 `0101` b2 b1 b0.
- R6: All 256 bytes give distinct words. Each word contains `0101` at some bit offset. No byte other than `6Ah` gives a word whose bits 9:4 equal `010101`.
- R7: A byte presented with `din_vld_i` high appears on `code_o` after the next rising clock edge, with `idle_o` low.
- R8: With `idle_req_i` high and `din_vld_i` low, each clock emits an idle word with `idle_o` high. The first idle word after reset is `155h`, and successive idle words alternate with `2AAh`. The alternation phase is kept across data words and hold cycles.
- R9: When `din_vld_i` and `idle_req_i` are both high, the byte is encoded and the idle phase does not advance.
- R10: With `din_vld_i` and `idle_req_i` both low, `code_o` and `idle_o` keep their values.
- R11: A clock edge with `rst_n` low sets `code_o` to 0 and `idle_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| din_i | input | 8 | Byte to encode |
| din_vld_i | input | 1 | Byte strobe; loads the encoded byte on the next edge |
| idle_req_i | input | 1 | Requests an idle word when no byte is offered |
| code_o | output | 10 | Registered code word |
| idle_o | output | 1 | High when `code_o` holds an idle word |

## Verification
The hardest situation to reach is an idle phase that survives interruptions. This covers an idle request that arrives in the same cycle as a byte, and an idle stream that resumes after data and hold cycles. The stimulus enters idle for an odd number of words and interrupts it with a byte plus a simultaneous idle request. It then adds several quiet cycles before requesting idle again, so a wrongly advanced or reset phase shows up as the wrong pattern. Uniqueness and the reserved range are checked by sweeping all 256 bytes and keeping a record of every word already seen.

// File: rtl/mkenc_pkg.sv
// Package: shared widths, constants and types for the marker encoder.
// Assumes: byte in, 10-bit word out; the constants below fix the code.
package mkenc_pkg;
    localparam int DATA_W   = 8;
    localparam int CODE_W   = 10;
    localparam int MARK_W   = 4;
    localparam int GROUPS   = 4;
    localparam int GSEL_W   = $clog2(GROUPS);

    localparam logic [MARK_W-1:0] MARKER    = 4'b0101;
    localparam logic [CODE_W-1:0] IDLE_EVEN = 10'h155;
    localparam logic [CODE_W-1:0] IDLE_ODD  = 10'h2AA;
    localparam logic [DATA_W-1:0] RSV_BYTE  = 8'h6A;
    localparam logic [CODE_W-1:0] RSV_WORD  = 10'h154;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [CODE_W-1:0] word_t;

    // Returns 1 when the marker appears at any offset of the word.
    function automatic logic has_marker(input word_t w);
        logic hit;
        hit = 1'b0;
        for (int p = 0; p <= CODE_W - MARK_W; p++) begin
            if (w[p +: MARK_W] == MARKER) hit = 1'b1;
        end
        return hit;
    endfunction
endpackage

// File: rtl/mkenc_map.sv
// Module: mkenc_map
// Combinational byte-to-word mapping. One candidate word is built per group
// (selected by the top two byte bits). A final mux picks the live group.
// Assumes: pure combinational; caller registers the result.
module mkenc_map
    import mkenc_pkg::*;
(
    input  byte_t din,
    output word_t word
);
    localparam int SUB_W = DATA_W - GSEL_W;

    logic [SUB_W-1:0]  sub;
    logic [GSEL_W-1:0] grp;
    word_t             cand [GROUPS];

    assign sub = din[SUB_W-1:0];
    assign grp = din[DATA_W-1 -: GSEL_W];

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        if (g == 0) begin : g_lo
            // Group 0: alternate layout when sub[5:4] == 01, marker high otherwise.
            always_comb begin
                if (sub[5:4] == 2'b01)
                    cand[g] = {1'b1, sub[2], sub[3], sub[1], 1'b0, MARKER, sub[0]};
                else
                    cand[g] = {MARKER, sub[5:0]};
            end
        end else if (g == 1) begin : g_rsv
            // Group 1: reserved pattern maps to a fixed word, else marker after b5.
            always_comb begin
                if (sub == RSV_BYTE[SUB_W-1:0])
                    cand[g] = RSV_WORD;
                else
                    cand[g] = {sub[5], MARKER, sub[4:0]};
            end
        end else if (g == 2) begin : g_mid
            // Group 2: marker at the bottom for sub[5:4] == 01, mid-word otherwise.
            always_comb begin
                if (sub[5:4] == 2'b01)
                    cand[g] = {sub[3:2], 2'b00, sub[1:0], MARKER};
                else
                    cand[g] = {sub[5:4], MARKER, sub[3:0]};
            end
        end else begin : g_hi
            // Group 3: marker at the bottom for sub[4:3] == 01, split layout otherwise.
            always_comb begin
                if (sub[4:3] == 2'b01)
                    cand[g] = {sub[5], sub[2], 2'b11, sub[1:0], MARKER};
                else
                    cand[g] = {sub[5:3], MARKER, sub[2:0]};
            end
        end
    end

    // Select the candidate of the group named by the byte's top bits.
    always_comb begin
        word = cand[grp];
    end
endmodule

// File: rtl/mkenc_idle.sv
// Module: mkenc_idle
// Idle pattern generator: a one-bit phase picks between the two idle words.
// Assumes: 'take' is high only in cycles where an idle word is loaded.
module mkenc_idle
    import mkenc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  take,
    output word_t pattern
);
    logic phase_q;

    // Advance the phase each time an idle word is consumed.
    always_ff @(posedge clk) begin
        if (!rst_n)    phase_q <= 1'b0;
        else if (take) phase_q <= ~phase_q;
    end

    // Map the phase onto its idle word.
    always_comb begin
        pattern = phase_q ? IDLE_ODD : IDLE_EVEN;
    end

    // After an idle word is consumed, the offered pattern must differ.
    AST_IDLE_PHASE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> pattern != $past(pattern)); // R8
endmodule

// File: rtl/mkenc_outreg.sv
// Module: mkenc_outreg
// Output register: loads a data word (priority) or an idle word, else holds.
// Assumes: load_data and load_idle may both be high; data wins.
module mkenc_outreg
    import mkenc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load_data,
    input  logic  load_idle,
    input  word_t data_word,
    input  word_t idle_word,
    output word_t word_q,
    output logic  idle_q
);
    // Register the chosen word and its idle flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            idle_q <= 1'b0;
        end else if (load_data) begin
            word_q <= data_word;
            idle_q <= 1'b0;
        end else if (load_idle) begin
            word_q <= idle_word;
            idle_q <= 1'b1;
        end
    end

    AST_HOLD_WHEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_data && !load_idle) |=> ($stable(word_q) && $stable(idle_q))); // R10
endmodule

// File: rtl/mkenc_top.sv
// Module: mkenc_top
// Marker-embedding byte encoder with registered output and idle filler.
// Assumes: synchronous active-low reset; one byte per strobed clock.
module mkenc_top
    import mkenc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din_i,
    input  logic              din_vld_i,
    input  logic              idle_req_i,
    output logic [CODE_W-1:0] code_o,
    output logic              idle_o
);
    word_t enc_word;
    word_t idle_word;
    logic  take_idle;
    logic  live_q;

    // Idle is consumed only when no byte competes for the register.
    assign take_idle = idle_req_i & ~din_vld_i;

    mkenc_map u_map (
        .din  (din_i),
        .word (enc_word)
    );

    mkenc_idle u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take_idle),
        .pattern (idle_word)
    );

    mkenc_outreg u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_data (din_vld_i),
        .load_idle (idle_req_i),
        .data_word (enc_word),
        .idle_word (idle_word),
        .word_q    (code_o),
        .idle_q    (idle_o)
    );

    // Marks that at least one cycle has passed since reset, for $past use.
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    AST_DATA_FLAG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        din_vld_i |=> !idle_o); // R7
    AST_IDLE_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        idle_o |-> (code_o == IDLE_EVEN || code_o == IDLE_ODD)); // R8
    AST_IDLE_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(take_idle) && take_idle) |=> code_o != $past(code_o)); // R8
    AST_RESERVED_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (din_vld_i && din_i == RSV_BYTE) |=> code_o == RSV_WORD); // R3
    AST_NO_RESERVED_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (din_vld_i && din_i != RSV_BYTE) |=> code_o[CODE_W-1:MARK_W] != 6'h15); // R6
    AST_MARKER_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        din_vld_i |=> has_marker(code_o)); // R6
endmodule

// File: tb/tb_mkenc_top.sv
`timescale 1ns/1ps
module tb_mkenc_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] din_i = '0;
    logic       din_vld_i = 1'b0;
    logic       idle_req_i = 1'b0;
    logic [9:0] code_o;
    logic       idle_o;

    int n_chk = 0;
    int n_bad = 0;
    logic seen [1024];

    always #4 clk = ~clk;

    mkenc_top dut (
        .clk(clk), .rst_n(rst_n), .din_i(din_i), .din_vld_i(din_vld_i),
        .idle_req_i(idle_req_i), .code_o(code_o), .idle_o(idle_o)
    );

    // {byte, expected word}, worked out by hand from R1..R5
    localparam int NV = 15;
    localparam logic [17:0] VEC [NV] = '{
        {8'h00, 10'h140}, {8'h3F, 10'h17F},                  // R1
        {8'h15, 10'h30B}, {8'h1E, 10'h3CA},                  // R2
        {8'h6A, 10'h154}, {8'h40, 10'h0A0}, {8'h7F, 10'h2BF}, {8'h6B, 10'h2AB}, // R3
        {8'h95, 10'h115}, {8'h80, 10'h050}, {8'hBC, 10'h35C}, // R4
        {8'hC8, 10'h0C5}, {8'hEF, 10'h3F5}, {8'hFF, 10'h3AF}, {8'hC0, 10'h028}  // R5
    };

    function automatic logic [9:0] model(input logic [7:0] d);
        case (d[7:6])
            2'd0: return (d[5:4] == 2'b01) ? {1'b1, d[2], d[3], d[1], 5'b00101, d[0]}
                                           : {4'b0101, d[5:0]};
            2'd1: return (d[5:0] == 6'h2A) ? 10'h154 : {d[5], 4'b0101, d[4:0]};
            2'd2: return (d[5:4] == 2'b01) ? {d[3:2], 2'b00, d[1:0], 4'b0101}
                                           : {d[5:4], 4'b0101, d[3:0]};
            default: return (d[4:3] == 2'b01) ? {d[5], d[2], 2'b11, d[1:0], 4'b0101}
                                              : {d[5:3], 4'b0101, d[2:0]};
        endcase
    endfunction

    task automatic check(input string req, input logic [9:0] got_w, input logic got_f,
                         input logic [9:0] exp_w, input logic exp_f);
        n_chk++;
        if (got_w !== exp_w || got_f !== exp_f) begin
            n_bad++;
            $display("FAIL %s: got word %h flag %b, expected word %h flag %b",
                     req, got_w, got_f, exp_w, exp_f);
        end
    endtask

    // Drive inputs on a falling edge, sample at the next falling edge.
    task automatic step(input logic vld, input logic idl, input logic [7:0] d);
        din_vld_i = vld; idle_req_i = idl; din_i = d;
        @(negedge clk);
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 1024; i++) seen[i] = 1'b0;
        repeat (3) @(negedge clk);
        check("R11 reset", code_o, idle_o, 10'h000, 1'b0);
        rst_n = 1'b1;

        // Table walk (R1..R5, R7)
        for (int v = 0; v < NV; v++) begin
            step(1'b1, 1'b0, VEC[v][17:10]);
            check($sformatf("R1-5 vector %0d byte %h (R7)", v, VEC[v][17:10]),
                  code_o, idle_o, VEC[v][9:0], 1'b0);
        end

        // Exhaustive sweep: model match, uniqueness, marker, reserved range (R6)
        for (int b = 0; b < 256; b++) begin
            logic ok;
            step(1'b1, 1'b0, b[7:0]);
            check("R6 sweep", code_o, idle_o, model(b[7:0]), 1'b0);
            ok = !seen[code_o] && mkenc_pkg::has_marker(code_o) &&
                 (b == 8'h6A || code_o[9:4] != 6'h15);
            seen[code_o] = 1'b1;
            n_chk++;
            if (!ok) begin
                n_bad++;
                $display("FAIL R6 byte %h: got word %h, expected unique marked word", b[7:0], code_o);
            end
        end

        // Hold (R10)
        step(1'b1, 1'b0, 8'h95);
        step(1'b0, 1'b0, 8'h00);
        check("R10 hold 1", code_o, idle_o, 10'h115, 1'b0);
        step(1'b0, 1'b0, 8'hFF);
        check("R10 hold 2", code_o, idle_o, 10'h115, 1'b0);

        // Reset again, then idle alternation from a known phase (R8, R11)
        rst_n = 1'b0;
        step(1'b0, 1'b0, 8'h00);
        check("R11 reset after data", code_o, idle_o, 10'h000, 1'b0);
        rst_n = 1'b1;
        step(1'b0, 1'b1, 8'h00); check("R8 idle 1", code_o, idle_o, 10'h155, 1'b1);
        step(1'b0, 1'b1, 8'h00); check("R8 idle 2", code_o, idle_o, 10'h2AA, 1'b1);
        step(1'b0, 1'b1, 8'h00); check("R8 idle 3", code_o, idle_o, 10'h155, 1'b1);

        // Byte and idle together: byte wins, phase frozen (R9)
        step(1'b1, 1'b1, 8'h6A);
        check("R9 data over idle", code_o, idle_o, 10'h154, 1'b0);
        step(1'b0, 1'b0, 8'h00);
        check("R10 hold after data", code_o, idle_o, 10'h154, 1'b0);
        step(1'b0, 1'b0, 8'h00);
        step(1'b0, 1'b1, 8'h00);
        check("R9 phase kept", code_o, idle_o, 10'h2AA, 1'b1);
        step(1'b0, 1'b0, 8'h00);
        check("R10 hold idle", code_o, idle_o, 10'h2AA, 1'b1);
        step(1'b0, 1'b1, 8'h00);
        check("R8 resume", code_o, idle_o, 10'h155, 1'b1);
        step(1'b1, 1'b0, 8'hC0);
        check("R7 flag drops", code_o, idle_o, 10'h028, 1'b0);
        step(1'b0, 1'b0, 8'h00);

        finish_run();
    end
endmodule